// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block sits passively behind an SPI byte deserializer. It classifies every transaction bounded by chip select without ever driving the bus. While select is low, it captures the header byte and the next two bytes in each direction, and it counts the bytes. When select rises, it decodes the command class and register address from the header. It then checks the frame length and header form for that class, and reports the results together with one error flag per kind of violation.

Register accesses are resolved against a two-bit bank. The monitor learns the bank by watching writes, bit-set operations and bit-clear operations aimed at the bank-control register. Until both bank bits have been seen, every register access is reported as made in an unknown bank. Within a known bank, a per-bank mask marks the registers whose reads need an extra dummy byte. The monitor checks that each read uses the right frame length for its register, and it reports the returned byte from the correct position.

Top module: `spi_cmd_monitor`

## Requirements
- R1: Bytes are counted only on clock edges where `byte_vld` is high and `cs_n` is low. A frame ends at the first edge where `cs_n` is sampled high after being low. The outputs update on that edge, and `frame_done` is high for exactly the following cycle. The outputs then hold their values until the next non-empty frame ends.
- R2: `cmd_code` is header bits 7:5, and `reg_addr` is header bits 4:0. The codes are 0 register read, 1 buffer read, 2 register write, 3 buffer write, 4 bit set, 5 bit clear and 7 system reset. Code 6 raises `err_opcode` and no other error flag.
- R3: A frame that breaks a length rule raises `err_length`. Register write, bit set and bit clear must be exactly 2 bytes long. System reset must be exactly 1 byte long. A register read must be 2 or 3 bytes long.
- R4: A buffer read must have a header of exactly 0x3A, and a buffer write must have a header of exactly 0x7A. Any other header raises `err_header`. Buffer frames of any length raise no length error.
- R5: A register read of legal length, made while the bank is known, raises `err_dummy` in two cases. The first is a register whose bit is set in `DUMMY_MASK[32*bank + addr]` read with a length other than 3. The second is any other register read with a length other than 2. No dummy check is made while the bank is unknown.
- R6: For a register read of legal length, `rd_data` is the MISO byte at position 2 (counting from 0) in a 3-byte frame, and the MISO byte at position 1 in a 2-byte frame. For every other frame, `rd_data` is 0.
- R7: A 2-byte register write to address `BANK_REG` (0x1F) loads bank bit 1 from data bit 1 and bank bit 0 from data bit 0, and marks both bits known.
- R8: A 2-byte bit set to `BANK_REG` sets each bank bit whose mask bit (data bits 1:0) is 1. A 2-byte bit clear to `BANK_REG` clears each such bank bit. Each targeted bit becomes known, and untargeted bits keep both their value and their known state.
- R9: `bank_known` is 1 only when both bank bits are known. Register accesses (codes 0, 2, 4 and 5) made while the bank is not fully known raise `err_bank`. `bank` and `bank_known` report the state before the frame's own update. Reset returns both bits to unknown and the bank value to 0.
- R10: A frame with no bytes produces no `frame_done` and leaves every output unchanged.
- R11: Frames that break a length rule, frames to other addresses and frames of other classes leave the bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| byte_vld | input | 1 | One-cycle strobe for a completed byte pair |
| mosi_byte | input | 8 | Byte sent to the device |
| miso_byte | input | 8 | Byte returned by the device |
| frame_done | output | 1 | One-cycle pulse after a non-empty frame ends |
| cmd_code | output | 3 | Decoded command class |
| reg_addr | output | 5 | Register address from the header |
| bank | output | 2 | Bank in use for the frame |
| bank_known | output | 1 | Both bank bits known for the frame |
| rd_data | output | 8 | Data byte returned by a register read |
| err_opcode | output | 1 | Reserved command code |
| err_length | output | 1 | Illegal frame length |
| err_header | output | 1 | Illegal buffer-command header |
| err_dummy | output | 1 | Dummy-byte rule broken |
| err_bank | output | 1 | Register access in an unknown bank |

## Verification
The hardest state to reach is a half-learned bank, where one bank bit is known and the other is not. Reaching it takes a reset followed by a masked bit set that touches only one bank bit. A register read issued next must still report an unknown bank. A bit clear that touches only the other bank bit must then complete the bank and make the dummy check active. Every bank-dependent check depends on the history of earlier frames. The stimulus table is therefore walked as one ordered sequence: bank writes, sets and clears are placed between reads whose results show the bank that each update left behind.

// File: rtl/spi_cmd_monitor.sv
module spi_cmd_monitor #(
  parameter int           CNT_W      = 8,
  parameter logic [4:0]   BANK_REG   = 5'h1F,
  parameter logic [127:0] DUMMY_MASK = {32'h0000_00FF, 32'h0000_FFFF, 32'h0, 32'h0}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       byte_vld,
  input  logic [7:0] mosi_byte,
  input  logic [7:0] miso_byte,
  output logic       frame_done,
  output logic [2:0] cmd_code,
  output logic [4:0] reg_addr,
  output logic [1:0] bank,
  output logic       bank_known,
  output logic [7:0] rd_data,
  output logic       err_opcode,
  output logic       err_length,
  output logic       err_header,
  output logic       err_dummy,
  output logic       err_bank
);

  localparam logic [2:0] OP_RREG = 3'd0, OP_RBUF = 3'd1, OP_WREG = 3'd2, OP_WBUF = 3'd3,
                         OP_BSET = 3'd4, OP_BCLR = 3'd5, OP_BAD  = 3'd6, OP_RST  = 3'd7;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] THREE = CNT_W'(3);

  logic             cs_q;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       hdr, mosi1, miso1, miso2;
  logic [1:0]       bsel_q, known_q;

  wire take      = byte_vld & ~cs_n;
  wire frame_end = cs_n & ~cs_q & (cnt != '0);

  wire [2:0] op   = hdr[7:5];
  wire [4:0] addr = hdr[4:0];
  wire len1 = (cnt == ONE);
  wire len2 = (cnt == TWO);
  wire len3 = (cnt == THREE);

  wire is_reg     = (op == OP_RREG) | (op == OP_WREG) | (op == OP_BSET) | (op == OP_BCLR);
  wire both_known = &known_q;

  logic len_ok;
  always_comb begin
    case (op)
      OP_RREG:                   len_ok = len2 | len3;
      OP_WREG, OP_BSET, OP_BCLR: len_ok = len2;
      OP_RST:                    len_ok = len1;
      default:                   len_ok = 1'b1;
    endcase
  end

  wire hdr_bad = ((op == OP_RBUF) & (hdr != 8'h3A)) | ((op == OP_WBUF) & (hdr != 8'h7A));

  wire [6:0]  mask_base = {bsel_q, 5'd0};
  wire [31:0] bank_mask = DUMMY_MASK[mask_base +: 32];
  wire        dummy_reg = bank_mask[addr];
  wire        dummy_bad = (op == OP_RREG) & len_ok & both_known & (dummy_reg ? ~len3 : ~len2);

  wire [7:0] read_val = ((op == OP_RREG) & len_ok) ? (len3 ? miso2 : miso1) : 8'h00;

  logic [1:0] bsel_d, known_d;
  always_comb begin
    bsel_d  = bsel_q;
    known_d = known_q;
    if (len_ok && addr == BANK_REG) begin
      case (op)
        OP_WREG: begin bsel_d = mosi1[1:0];           known_d = 2'b11;               end
        OP_BSET: begin bsel_d = bsel_q | mosi1[1:0];  known_d = known_q | mosi1[1:0]; end
        OP_BCLR: begin bsel_d = bsel_q & ~mosi1[1:0]; known_d = known_q | mosi1[1:0]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      cnt   <= '0;
      hdr   <= '0;
      mosi1 <= '0;
      miso1 <= '0;
      miso2 <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n)
        cnt <= '0;
      else if (take && cnt != CNT_MAX)
        cnt <= cnt + ONE;
      if (take) begin
        if (cnt == '0) hdr <= mosi_byte;
        if (cnt == ONE) begin
          mosi1 <= mosi_byte;
          miso1 <= miso_byte;
        end
        if (cnt == TWO) miso2 <= miso_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsel_q  <= 2'b00;
      known_q <= 2'b00;
    end else if (frame_end) begin
      bsel_q  <= bsel_d;
      known_q <= known_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      cmd_code   <= '0;
      reg_addr   <= '0;
      bank       <= '0;
      bank_known <= 1'b0;
      rd_data    <= '0;
      err_opcode <= 1'b0;
      err_length <= 1'b0;
      err_header <= 1'b0;
      err_dummy  <= 1'b0;
      err_bank   <= 1'b0;
    end else begin
      frame_done <= frame_end;
      if (frame_end) begin
        cmd_code   <= op;
        reg_addr   <= addr;
        bank       <= bsel_q;
        bank_known <= both_known;
        rd_data    <= read_val;
        err_opcode <= (op == OP_BAD);
        err_length <= ~len_ok;
        err_header <= hdr_bad;
        err_dummy  <= dummy_bad;
        err_bank   <= is_reg & ~both_known;
      end
    end
  end

  p_done_after_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(cs_n));

  p_done_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_reserved_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_opcode |-> !err_length && !err_header && !err_dummy && !err_bank);

  p_header_buffer_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_header |-> (cmd_code == OP_RBUF || cmd_code == OP_WBUF));

  p_dummy_known_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_dummy |-> (cmd_code == OP_RREG && bank_known && !err_length));

  p_known_bit0_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    known_q[0] |=> known_q[0]);

  p_known_bit1_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    known_q[1] |=> known_q[1]);

  p_empty_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(cnt) != '0);

  p_bank_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(bsel_q) && $stable(known_q));

endmodule

// File: tb/test_spi_cmd_monitor.sv
module test_spi_cmd_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic byte_vld = 1'b0;
  logic [7:0] mosi_byte = '0;
  logic [7:0] miso_byte = '0;
  logic frame_done, bank_known, err_opcode, err_length, err_header, err_dummy, err_bank;
  logic [2:0] cmd_code;
  logic [4:0] reg_addr;
  logic [1:0] bank;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_monitor i_spi_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
    .mosi_byte(mosi_byte), .miso_byte(miso_byte),
    .frame_done(frame_done), .cmd_code(cmd_code), .reg_addr(reg_addr),
    .bank(bank), .bank_known(bank_known), .rd_data(rd_data),
    .err_opcode(err_opcode), .err_length(err_length), .err_header(err_header),
    .err_dummy(err_dummy), .err_bank(err_bank)
  );

  // {len, b0, b1, b2, m1, m2, cmd, known, bank, errs(opc,len,hdr,dum,bank), data}
  localparam logic [62:0] VEC [NV] = '{
    {4'd2, 8'h05, 8'h00, 8'h00, 8'h11, 8'h00, 3'd0, 1'b0, 2'd0, 5'b00001, 8'h11},
    {4'd2, 8'h5F, 8'h02, 8'h00, 8'h00, 8'h00, 3'd2, 1'b0, 2'd0, 5'b00001, 8'h00},
    {4'd3, 8'h03, 8'h00, 8'h00, 8'h00, 8'h33, 3'd0, 1'b1, 2'd2, 5'b00000, 8'h33},
    {4'd2, 8'h03, 8'h00, 8'h00, 8'h44, 8'h00, 3'd0, 1'b1, 2'd2, 5'b00010, 8'h44},
    {4'd3, 8'h14, 8'h00, 8'h00, 8'h00, 8'h55, 3'd0, 1'b1, 2'd2, 5'b00010, 8'h55},
    {4'd2, 8'h9F, 8'h01, 8'h00, 8'h00, 8'h00, 3'd4, 1'b1, 2'd2, 5'b00000, 8'h00},
    {4'd3, 8'h07, 8'h00, 8'h00, 8'h00, 8'h66, 3'd0, 1'b1, 2'd3, 5'b00000, 8'h66},
    {4'd2, 8'hBF, 8'h02, 8'h00, 8'h00, 8'h00, 3'd5, 1'b1, 2'd3, 5'b00000, 8'h00},
    {4'd2, 8'h07, 8'h00, 8'h00, 8'h77, 8'h00, 3'd0, 1'b1, 2'd1, 5'b00000, 8'h77},
    {4'd3, 8'h5F, 8'h00, 8'h00, 8'h00, 8'h00, 3'd2, 1'b1, 2'd1, 5'b01000, 8'h00},
    {4'd1, 8'hE0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd7, 1'b1, 2'd1, 5'b00000, 8'h00},
    {4'd2, 8'hE0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd7, 1'b1, 2'd1, 5'b01000, 8'h00},
    {4'd1, 8'hC0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd6, 1'b1, 2'd1, 5'b10000, 8'h00},
    {4'd3, 8'h3A, 8'h00, 8'h00, 8'hAA, 8'hBB, 3'd1, 1'b1, 2'd1, 5'b00000, 8'h00},
    {4'd2, 8'h3B, 8'h00, 8'h00, 8'h00, 8'h00, 3'd1, 1'b1, 2'd1, 5'b00100, 8'h00},
    {4'd1, 8'h7A, 8'h00, 8'h00, 8'h00, 8'h00, 3'd3, 1'b1, 2'd1, 5'b00000, 8'h00},
    {4'd2, 8'h70, 8'h00, 8'h00, 8'h00, 8'h00, 3'd3, 1'b1, 2'd1, 5'b00100, 8'h00},
    {4'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1, 2'd1, 5'b01000, 8'h00},
    {4'd2, 8'h85, 8'h03, 8'h00, 8'h00, 8'h00, 3'd4, 1'b1, 2'd1, 5'b00000, 8'h00},
    {4'd3, 8'h9F, 8'h03, 8'h00, 8'h00, 8'h00, 3'd4, 1'b1, 2'd1, 5'b01000, 8'h00},
    {4'd2, 8'h00, 8'h00, 8'h00, 8'h5A, 8'h00, 3'd0, 1'b1, 2'd1, 5'b00000, 8'h5A}
  };

  string tags [NV];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] m1, input logic [7:0] m2);
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld  = 1'b1;
      mosi_byte = (i == 0) ? b0 : (i == 1) ? b1 : b2;
      miso_byte = (i == 1) ? m1 : (i == 2) ? m2 : 8'h00;
      @(negedge clk) byte_vld = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tags = '{"R9", "R7", "R5", "R5", "R5", "R8", "R5", "R8", "R8", "R3", "R11",
             "R3", "R2", "R4", "R4", "R4", "R4", "R3", "R11", "R11", "R6"};
    do_reset();

    // R1: reset state
    chk("R1", "reset outputs",
        32'({frame_done, cmd_code, reg_addr, bank, bank_known, rd_data,
             err_opcode, err_length, err_header, err_dummy, err_bank}), 32'd0);

    for (int v = 0; v < NV; v++) begin
      send(int'(VEC[v][62:59]), VEC[v][58:51], VEC[v][50:43], VEC[v][42:35],
           VEC[v][34:27], VEC[v][26:19]);
      chk(tags[v], $sformatf("vector %0d done", v), 32'(frame_done), 32'd1);
      chk(tags[v], $sformatf("vector %0d result", v),
          32'({cmd_code, reg_addr, bank_known, bank, err_opcode, err_length, err_header,
               err_dummy, err_bank, rd_data}),
          32'({VEC[v][18:16], VEC[v][55:51], VEC[v][15], VEC[v][14:13], VEC[v][12:8], VEC[v][7:0]}));
    end

    // R1: done pulse lasts one cycle
    @(negedge clk);
    chk("R1", "done drops", 32'(frame_done), 32'd0);

    // R10: empty frame leaves outputs untouched
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R10", "empty done", 32'(frame_done), 32'd0);
    chk("R10", "empty held", 32'({cmd_code, reg_addr, rd_data}), 32'({3'd0, 5'd0, 8'h5A}));

    // R1: strobe outside select is not counted
    @(negedge clk) begin byte_vld = 1'b1; mosi_byte = 8'hE0; end
    @(negedge clk) byte_vld = 1'b0;
    send(1, 8'hE0, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R1", "stray strobe ignored", 32'({cmd_code, err_length}), 32'({3'd7, 1'b0}));

    // R4: long buffer write
    send(20, 8'h7A, 8'hC3, 8'hC3, 8'h00, 8'h00);
    chk("R4", "long buffer write", 32'({cmd_code, err_length, err_header}), 32'({3'd3, 2'b00}));

    // R9: reset forgets the bank
    do_reset();
    send(2, 8'h00, 8'h00, 8'h00, 8'h21, 8'h00);
    chk("R9", "unknown after reset", 32'({bank_known, bank, err_bank}), 32'({1'b0, 2'd0, 1'b1}));

    // R8 and R9: half-learned bank
    send(2, 8'h9F, 8'h01, 8'h00, 8'h00, 8'h00);
    send(2, 8'h00, 8'h00, 8'h00, 8'h22, 8'h00);
    chk("R9", "one bit known", 32'({bank_known, bank, err_bank}), 32'({1'b0, 2'd1, 1'b1}));
    send(2, 8'hBF, 8'h02, 8'h00, 8'h00, 8'h00);
    send(2, 8'h00, 8'h00, 8'h00, 8'h23, 8'h00);
    chk("R8", "clear completes bank", 32'({bank_known, bank, err_bank, err_dummy, rd_data}),
        32'({1'b1, 2'd1, 1'b0, 1'b0, 8'h23}));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule